// File: doc/BRIEF.md
# Sign-Classifying Register ALU

This block executes register-register operations that return two values. The arithmetic or logic result replaces the first source operand in place. A separate destination register receives a small code that tells whether that result is zero, negative or positive. The block contains a 32-entry register file with two read ports and two write ports, a five-function ALU, and a two's-complement classifier that compares the result against zero.

A decoder outside the block supplies three register indices, a 3-bit operation code, and two write enables. One enable covers the in-place result write and the other covers the code write. Reads are combinational. Both writes commit on the same rising clock edge, so one instruction finishes in one cycle. Register contents can be observed through the two read ports.

Top module: `signcode_exec_unit`

## Requirements
- R1: After reset every register reads zero on both read ports.
- R2: The operation code selects the function: 3'b000 bitwise AND, 3'b001 bitwise OR, 3'b100 sum, 3'b101 difference (first operand minus second), 3'b110 bitwise XOR. Any other code gives a result of zero. The result appears combinationally on `alu_result`.
- R3: When `res_wr_en` is high, the result is written on the rising edge into the register named by `src_a_idx`, which is not the destination index.
- R4: A result equal to zero gives code 1 on `class_code`.
- R5: A result that is negative as a signed 32-bit value gives code 2. This includes 32'h8000_0000.
- R6: A result that is nonzero and non-negative gives code 3. This includes 32'h7FFF_FFFF.
- R7: When `code_wr_en` is high, the code, zero-extended to 32 bits, is written on the rising edge into the register named by `dst_idx`.
- R8: Register 0 always reads zero. Writes to it from either write port are ignored.
- R9: When `src_a_idx` equals `dst_idx` and both enables are high, the register ends up holding the code.
- R10: Reads are combinational and show the value from before the write of the current cycle.
- R11: With both enables low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset, clears all registers |
| src_a_idx | input | 5 | First operand index, also the target of the result write |
| src_b_idx | input | 5 | Second operand index |
| dst_idx | input | 5 | Target of the classification code write |
| op_sel | input | 3 | Operation code |
| res_wr_en | input | 1 | Enables the in-place result write |
| code_wr_en | input | 1 | Enables the code write |
| opa_data | output | 32 | Current contents of register `src_a_idx` |
| opb_data | output | 32 | Current contents of register `src_b_idx` |
| alu_result | output | 32 | Result of the selected operation |
| class_code | output | 2 | Classification of `alu_result` |

## Verification
On every cycle, the assertions check that the classifier agrees with the ALU output for zero, negative and positive results. They also check that register 0 reads zero, and that each enabled write shows up on the matching read port one cycle later, with the code winning on an index clash. The directed scenarios are the only place where the bench shows that the arithmetic is correct for particular operands (5+8, 5-8, 7 AND 8). The same holds for the sign boundaries at 32'h8000_0000 and 32'h7FFF_FFFF, for reads returning pre-write values, and for disabled writes leaving every register untouched.

// File: rtl/signcode_pkg.sv
package signcode_pkg;
    localparam int DATA_W = 32;
    localparam int REG_N  = 32;
    localparam int IDX_W  = $clog2(REG_N);
    localparam int OP_W   = 3;
    localparam int CODE_W = 2;

    localparam logic [OP_W-1:0] OP_AND = 3'b000;
    localparam logic [OP_W-1:0] OP_OR  = 3'b001;
    localparam logic [OP_W-1:0] OP_ADD = 3'b100;
    localparam logic [OP_W-1:0] OP_SUB = 3'b101;
    localparam logic [OP_W-1:0] OP_XOR = 3'b110;

    localparam logic [CODE_W-1:0] CODE_ZERO = 2'd1;
    localparam logic [CODE_W-1:0] CODE_NEG  = 2'd2;
    localparam logic [CODE_W-1:0] CODE_POS  = 2'd3;
endpackage

// File: rtl/signcode_alu.sv
module signcode_alu
    import signcode_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic [OP_W-1:0]  op_sel,
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    output logic [WIDTH-1:0] res
);
    always_comb begin
        unique case (op_sel)
            OP_AND:  res = lhs & rhs;
            OP_OR:   res = lhs | rhs;
            OP_ADD:  res = lhs + rhs;
            OP_SUB:  res = lhs - rhs;
            OP_XOR:  res = lhs ^ rhs;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/signcode_classify.sv
module signcode_classify
    import signcode_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0]  value,
    output logic [CODE_W-1:0] code
);
    localparam logic [WIDTH-1:0] REF = '0;

    logic sign_v, sign_r, is_eq, is_lt;

    // Two's-complement compare: differing sign bits decide directly,
    // equal sign bits reduce to an unsigned compare.
    always_comb begin
        sign_v = value[WIDTH-1];
        sign_r = REF[WIDTH-1];
        is_eq  = (value == REF);
        if (sign_v != sign_r) is_lt = sign_v;
        else                  is_lt = (value < REF);
        if (is_eq)      code = CODE_ZERO;
        else if (is_lt) code = CODE_NEG;
        else            code = CODE_POS;
    end
endmodule

// File: rtl/signcode_regfile.sv
module signcode_regfile
    import signcode_pkg::*;
#(
    parameter int WIDTH = DATA_W,
    parameter int DEPTH = REG_N,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_a_idx,
    input  logic [AW-1:0]    rd_b_idx,
    output logic [WIDTH-1:0] rd_a_data,
    output logic [WIDTH-1:0] rd_b_data,
    input  logic             wr_lo_en,
    input  logic [AW-1:0]    wr_lo_idx,
    input  logic [WIDTH-1:0] wr_lo_data,
    input  logic             wr_hi_en,
    input  logic [AW-1:0]    wr_hi_idx,
    input  logic [WIDTH-1:0] wr_hi_data
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] regs;
    } rf_state_t;

    rf_state_t rf_d, rf_q;

    // Port "hi" is applied last, so it wins on an index clash.
    always_comb begin
        rf_d = rf_q;
        if (wr_lo_en && (wr_lo_idx != '0)) rf_d.regs[wr_lo_idx] = wr_lo_data;
        if (wr_hi_en && (wr_hi_idx != '0)) rf_d.regs[wr_hi_idx] = wr_hi_data;
        rf_d.regs[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign rd_a_data = (rd_a_idx == '0) ? '0 : rf_q.regs[rd_a_idx];
    assign rd_b_data = (rd_b_idx == '0) ? '0 : rf_q.regs[rd_b_idx];
endmodule

// File: rtl/signcode_exec_unit.sv
module signcode_exec_unit
    import signcode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  src_a_idx,
    input  logic [IDX_W-1:0]  src_b_idx,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic [OP_W-1:0]   op_sel,
    input  logic              res_wr_en,
    input  logic              code_wr_en,
    output logic [DATA_W-1:0] opa_data,
    output logic [DATA_W-1:0] opb_data,
    output logic [DATA_W-1:0] alu_result,
    output logic [CODE_W-1:0] class_code
);
    logic [DATA_W-1:0] code_ext;

    assign code_ext = {{(DATA_W-CODE_W){1'b0}}, class_code};

    signcode_alu #(.WIDTH(DATA_W)) i_alu (
        .op_sel (op_sel),
        .lhs    (opa_data),
        .rhs    (opb_data),
        .res    (alu_result)
    );

    signcode_classify #(.WIDTH(DATA_W)) i_cls (
        .value (alu_result),
        .code  (class_code)
    );

    signcode_regfile #(.WIDTH(DATA_W), .DEPTH(REG_N)) i_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_a_idx   (src_a_idx),
        .rd_b_idx   (src_b_idx),
        .rd_a_data  (opa_data),
        .rd_b_data  (opb_data),
        .wr_lo_en   (res_wr_en),
        .wr_lo_idx  (src_a_idx),
        .wr_lo_data (alu_result),
        .wr_hi_en   (code_wr_en),
        .wr_hi_idx  (dst_idx),
        .wr_hi_data (code_ext)
    );
endmodule

// File: rtl/signcode_exec_checker.sv
module signcode_exec_checker
    import signcode_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  src_a_idx,
    input logic [IDX_W-1:0]  src_b_idx,
    input logic [IDX_W-1:0]  dst_idx,
    input logic              res_wr_en,
    input logic              code_wr_en,
    input logic [DATA_W-1:0] opa_data,
    input logic [DATA_W-1:0] opb_data,
    input logic [DATA_W-1:0] alu_result,
    input logic [CODE_W-1:0] class_code
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (opa_data == '0 && opb_data == '0));

    assert_zero_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_result == '0) |-> (class_code == CODE_ZERO));

    assert_neg_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        alu_result[DATA_W-1] |-> (class_code == CODE_NEG));

    assert_pos_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_result != '0 && !alu_result[DATA_W-1]) |-> (class_code == CODE_POS));

    assert_reg0_reads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_idx == '0) |-> (opa_data == '0));

    assert_code_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (code_wr_en && dst_idx != '0) |=>
        ((src_a_idx != $past(dst_idx)) ||
         (opa_data == {{(DATA_W-CODE_W){1'b0}}, $past(class_code)})));

    assert_result_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_wr_en && src_a_idx != '0 && !(code_wr_en && dst_idx == src_a_idx)) |=>
        ((src_b_idx != $past(src_a_idx)) || (opb_data == $past(alu_result))));

    assert_clash_code_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_wr_en && code_wr_en && dst_idx == src_a_idx && dst_idx != '0) |=>
        ((src_b_idx != $past(dst_idx)) ||
         (opb_data == {{(DATA_W-CODE_W){1'b0}}, $past(class_code)})));
endmodule

bind signcode_exec_unit signcode_exec_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_a_idx  (src_a_idx),
    .src_b_idx  (src_b_idx),
    .dst_idx    (dst_idx),
    .res_wr_en  (res_wr_en),
    .code_wr_en (code_wr_en),
    .opa_data   (opa_data),
    .opb_data   (opb_data),
    .alu_result (alu_result),
    .class_code (class_code)
);

// File: tb/test_signcode_exec_unit.sv
module test_signcode_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_a_idx = '0, src_b_idx = '0, dst_idx = '0;
    logic [2:0]  op_sel = '0;
    logic        res_wr_en = 1'b0, code_wr_en = 1'b0;
    logic [31:0] opa_data, opb_data, alu_result;
    logic [1:0]  class_code;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [31:0] mdl [32];

    always #2 clk = ~clk;

    signcode_exec_unit i_signcode_exec_unit (
        .clk(clk), .rst_n(rst_n), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
        .dst_idx(dst_idx), .op_sel(op_sel), .res_wr_en(res_wr_en),
        .code_wr_en(code_wr_en), .opa_data(opa_data), .opb_data(opb_data),
        .alu_result(alu_result), .class_code(class_code)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] spec_res(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            3'b000: return a & b;
            3'b001: return a | b;
            3'b100: return a + b;
            3'b101: return a - b;
            3'b110: return a ^ b;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] spec_code(input logic [31:0] r);
        if (r == 0) return 32'd1;
        if ($signed(r) < 0) return 32'd2;
        return 32'd3;
    endfunction

    // Issue one operation, check comb outputs before the edge, update the model.
    task automatic run_op(input logic [2:0] op, input int a, input int b, input int d,
                          input bit wres, input bit wcode, input string tag);
        logic [31:0] er, ec;
        @(negedge clk);
        src_a_idx = 5'(a); src_b_idx = 5'(b); dst_idx = 5'(d);
        op_sel = op; res_wr_en = wres; code_wr_en = wcode;
        er = spec_res(op, mdl[a], mdl[b]);
        ec = spec_code(er);
        #1;
        chk({tag, " R2 result"}, alu_result, er);
        chk({tag, " R4/R5/R6 code"}, {30'd0, class_code}, ec);
        chk({tag, " R10 pre-write read"}, opa_data, mdl[a]);
        @(posedge clk);
        if (wres && a != 0) mdl[a] = er;
        if (wcode && d != 0) mdl[d] = ec;
        @(negedge clk);
        res_wr_en = 1'b0; code_wr_en = 1'b0;
    endtask

    task automatic check_reg(input int idx, input string tag);
        @(negedge clk);
        res_wr_en = 1'b0; code_wr_en = 1'b0;
        src_a_idx = 5'(idx); src_b_idx = 5'(idx);
        #1;
        chk({tag, " port a"}, opa_data, mdl[idx]);
        chk({tag, " port b"}, opb_data, mdl[idx]);
    endtask

    // Build a constant in register idx from r1 == 1 by shift-and-add.
    task automatic make_const(input int idx, input logic [31:0] val);
        bit seen = 0;
        run_op(3'b000, idx, 0, 0, 1, 0, "clear");
        for (int i = 31; i >= 0; i--) begin
            if (seen) run_op(3'b100, idx, idx, 0, 1, 0, "dbl");
            if (val[i]) begin
                run_op(3'b100, idx, 1, 0, 1, 0, "inc");
                seen = 1;
            end
        end
        check_reg(idx, "R3 build");
    endtask

    task automatic t_reset();
        for (int i = 0; i < 32; i++) mdl[i] = 32'h0;
        for (int i = 0; i < 32; i += 7) check_reg(i, "R1 reset");
        check_reg(31, "R1 reset");
    endtask

    task automatic t_seed();
        run_op(3'b000, 2, 0, 1, 0, 1, "R7 seed one");
        check_reg(1, "R7 code write");
        check_reg(2, "R11 rs untouched");
        make_const(5, 32'd5);
        make_const(8, 32'd8);
        make_const(7, 32'd7);
    endtask

    task automatic t_add_pos();
        run_op(3'b100, 5, 8, 10, 1, 1, "R6 add 5+8");
        check_reg(5, "R3 rs holds 13");
        chk("R3 value 13", mdl[5], 32'd13);
        check_reg(10, "R6 rd holds 3");
    endtask

    task automatic t_sub_neg();
        make_const(5, 32'd5);
        run_op(3'b101, 5, 8, 11, 1, 1, "R5 sub 5-8");
        check_reg(5, "R3 rs holds -3");
        chk("R3 value -3", mdl[5], 32'hFFFF_FFFD);
        check_reg(11, "R5 rd holds 2");
    endtask

    task automatic t_and_zero();
        run_op(3'b000, 7, 8, 12, 1, 1, "R4 and 7&8");
        check_reg(7, "R3 rs holds 0");
        check_reg(12, "R4 rd holds 1");
    endtask

    task automatic t_logic_ops();
        make_const(13, 32'd7);
        make_const(14, 32'd11);
        run_op(3'b110, 13, 14, 15, 1, 1, "R2 xor");
        check_reg(13, "R2 xor value");
        run_op(3'b001, 13, 8, 16, 1, 1, "R2 or");
        check_reg(13, "R2 or value");
        run_op(3'b011, 14, 8, 17, 1, 1, "R2 undefined op");
        check_reg(14, "R2 undefined op zero");
    endtask

    task automatic t_bounds();
        make_const(20, 32'h8000_0000);
        run_op(3'b001, 20, 0, 21, 0, 1, "R5 min negative");
        check_reg(21, "R5 code of 0x80000000");
        run_op(3'b101, 20, 1, 22, 1, 1, "R6 max positive");
        check_reg(22, "R6 code of 0x7fffffff");
        check_reg(20, "R3 holds 0x7fffffff");
    endtask

    task automatic t_reg_zero();
        run_op(3'b100, 0, 8, 0, 1, 1, "R8 write r0");
        check_reg(0, "R8 r0 stays zero");
    endtask

    task automatic t_clash();
        make_const(23, 32'd100);
        run_op(3'b100, 23, 8, 23, 1, 1, "R9 clash");
        check_reg(23, "R9 code wins");
        chk("R9 value 3", mdl[23], 32'd3);
    endtask

    task automatic t_disabled();
        run_op(3'b100, 8, 8, 24, 0, 0, "R11 no enables");
        check_reg(8, "R11 rs unchanged");
        check_reg(24, "R11 rd unchanged");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_seed();
        t_add_pos();
        t_sub_neg();
        t_and_zero();
        t_logic_ops();
        t_bounds();
        t_reg_zero();
        t_clash();
        t_disabled();
        if (!finished) begin
            finished = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule